// File: doc/BRIEF.md
# Three-Stage Pseudo-Random Test Pattern Source

This block produces a stream of 3-bit pseudo-random words. It is meant to drive the inputs of a small combinational block under self-test. Internally it is a three-stage linear feedback shift register. Each stored bit moves one place toward the most significant end. The bit that enters at the least significant end is the XOR of the top and bottom stages. From the seed `111` the register visits all seven non-zero values in one fixed order, then repeats.

The words leave on a valid/ready stream. `pat_valid` is low while reset is held and goes high on the first clock after reset is released. It then stays high, because a new pattern is always available. A consumer applies back-pressure by holding `pat_ready` low. While it does, the presented word stays unchanged for as many cycles as it likes. A word counts as consumed on a rising clock edge where both `pat_valid` and `pat_ready` are high, and the next word then appears. Reset is synchronous, reloads the seed and wins over any transfer in the same cycle.

Top module: `tpg3_source`

## Requirements
- R1: While `rst` is high at a clock edge, the next output is `pat_data` = 3'b111 (the seed) and `pat_valid` = 0.
- R2: `pat_valid` becomes 1 on the first edge at which `rst` is low, and stays 1 until reset is applied again.
- R3: At each edge with `pat_valid` and `pat_ready` both high, the word advances one step: new = {old[1], old[0], old[2] XOR old[0]}.
- R4: At an edge with `pat_ready` low, `pat_data` keeps its value.
- R5: Starting from the seed, the words are, MSB first, 111, 110, 101, 010, 100, 001, 011. The seventh transfer brings the word back to 111, so the period is 7.
- R6: Reset takes priority: with `rst` and `pat_ready` both high, the seed is loaded and no step happens.
- R7: With a non-zero seed, `pat_data` is never 000 while `pat_valid` is high. When the block is built with an all-zero seed, the word stays 000 forever, and the bench checks this lock-up state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| pat_ready | input | 1 | Consumer accepts the current word |
| pat_valid | output | 1 | A word is presented |
| pat_data | output | 3 | Current pattern word (register state) |

## Verification
The case that is hardest to reach from the ports is the all-zero lock-up state. No sequence of reset and ready inputs can ever lead into it from the fixed seed. The bench therefore builds a second instance with its seed parameter set to zero, drives it with the same stream of inputs, and checks that its word never leaves 000. A behavioural model that indexes a seven-entry list checks the main instance on every cycle. The stimulus includes runs of more than two periods, irregular stalls, and a reset that arrives in the middle of the sequence while a transfer is pending.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int unsigned STAGES = 3;
  typedef logic [STAGES-1:0] pat_t;
  localparam pat_t DEFAULT_SEED = '1;
  // feedback taps: top stage and bottom stage
  localparam int unsigned TAP_HI = STAGES - 1;
  localparam int unsigned TAP_LO = 0;
endpackage

// File: rtl/pgen_feedback.sv
module pgen_feedback
  import pgen_pkg::*;
(
  input  pat_t cur,
  output pat_t nxt
);
  // shift toward MSB; new LSB is XOR of the two taps
  for (genvar i = 1; i < STAGES; i++) begin : g_shift
    assign nxt[i] = cur[i-1];
  end
  assign nxt[0] = cur[TAP_HI] ^ cur[TAP_LO];
endmodule

// File: rtl/pgen_state.sv
module pgen_state
  import pgen_pkg::*;
#(
  parameter pat_t SEED = DEFAULT_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  pat_t nxt,
  output pat_t q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= nxt;
  end

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));
  a_r1_seed_load: assert property (@(posedge clk)
    rst |=> (q == SEED));
endmodule

// File: rtl/tpg3_source.sv
module tpg3_source
  import pgen_pkg::*;
#(
  parameter pat_t SEED = DEFAULT_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pat_ready,
  output logic             pat_valid,
  output logic [STAGES-1:0] pat_data
);
  pat_t state_q;
  pat_t state_nxt;
  logic valid_q;
  logic take;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= 1'b1;
  end

  assign take = valid_q & pat_ready;

  pgen_feedback u_fb (
    .cur (state_q),
    .nxt (state_nxt)
  );

  pgen_state #(.SEED(SEED)) u_st (
    .clk (clk),
    .rst (rst),
    .adv (take),
    .nxt (state_nxt),
    .q   (state_q)
  );

  assign pat_valid = valid_q;
  assign pat_data  = state_q;

  a_r6_reset_wins: assert property (@(posedge clk)
    rst |=> !pat_valid);
  a_r2_valid_sticks: assert property (@(posedge clk) disable iff (rst)
    pat_valid |=> pat_valid);

  if (SEED != '0) begin : g_live
    a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
      pat_valid |-> (pat_data != '0));
    a_r3_moves_on_take: assert property (@(posedge clk) disable iff (rst)
      (pat_valid && pat_ready) |=> (pat_data != $past(pat_data)));
  end
endmodule

// File: tb/tpg3_source_tb.sv
module tpg3_source_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pat_ready = 1'b0;
  logic pat_valid, lk_valid;
  logic [2:0] pat_data, lk_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference: MSB-first order of the seven words
  logic [2:0] ref_seq [$] = '{3'b111, 3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011};
  int idx = 0;
  bit m_valid = 0;

  always #4 clk = ~clk;  // 125 MHz

  tpg3_source u_dut (
    .clk(clk), .rst(rst), .pat_ready(pat_ready),
    .pat_valid(pat_valid), .pat_data(pat_data)
  );

  tpg3_source #(.SEED(3'b000)) u_lock (
    .clk(clk), .rst(rst), .pat_ready(pat_ready),
    .pat_valid(lk_valid), .pat_data(lk_data)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0;
      idx <= 0;
    end else begin
      if (m_valid && pat_ready) idx <= (idx + 1) % 7;
      m_valid <= 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (pat_valid !== m_valid) begin
        bad++;
        $display("FAIL %s/R2 valid: got %0b exp %0b", tag, pat_valid, m_valid);
      end
      total++;
      if (pat_data !== ref_seq[idx]) begin
        bad++;
        $display("FAIL %s data: got %03b exp %03b", tag, pat_data, ref_seq[idx]);
      end
      total++;
      if (lk_data !== 3'b000 || (pat_valid && pat_data == 3'b000)) begin
        bad++;
        $display("FAIL R7 lockup: got lock=%03b main=%03b exp lock=000 main!=000",
                 lk_data, pat_data);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R3"; rst = 0; pat_ready = 1;
    // R5: more than two full periods, wrap included
    repeat (16) @(negedge clk);
    tag = "R4";
    for (int i = 0; i < 24; i++) begin
      pat_ready = (i % 3 == 0) || (i % 5 == 1);
      @(negedge clk);
    end
    tag = "R6"; pat_ready = 1; rst = 1;
    repeat (2) @(negedge clk);
    tag = "R5"; rst = 0;
    repeat (9) @(negedge clk);
    tag = "R4"; pat_ready = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule